// File: doc/BRIEF.md
# Real-Mode Branch and Loop Sequencer

This block produces the next fetch location of a 16-bit real-mode fetch unit after a control-transfer instruction has been decoded. Each cycle in which `in_valid` is high it takes the current code segment and offset, the instruction length, a transfer class, the displacement or far-pointer fields, the count register and the zero flag. One cycle later it presents the new segment, the new offset, the updated count, the 20-bit physical fetch address, whether the transfer redirected the flow, and a one-cycle request to flush the prefetch queue.

Relative targets are measured from the offset of the following instruction (current offset plus length). Short and loop forms use an 8-bit signed displacement, the near form a full 16-bit one, and the far form loads segment and offset directly. Loop forms first decrement the count and then decide from the new count and, for the conditional forms, from the zero flag. Offsets wrap modulo 2^16 and physical addresses modulo 2^20.

Top module: `branch_loop_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, all outputs become zero at that edge.
- R2: Results appear exactly one clock after an edge where `in_valid` is high, with `out_valid` high for that one cycle; after an edge with `in_valid` low, `out_valid`, `taken` and `flush` are low and `cs_out`, `ip_out`, `cx_out`, `phys_addr` keep their values.
- R3: `phys_addr` equals `cs_out`*16 + `ip_out`, modulo 2^20 (segment 0723h, offset 0009h gives 07239h).
- R4: Class 0 (short jump): `ip_out` = `ip_in` + `ins_len` + sign-extended `disp[7:0]` modulo 2^16 and `cs_out` = `cs_in` (0723h:0009h, length 2, disp 04h gives offset 000Fh, address 0723Fh).
- R5: Class 1 (near jump): `ip_out` = `ip_in` + `ins_len` + `disp` modulo 2^16, `cs_out` = `cs_in`.
- R6: Class 2 (far jump): `cs_out` = `far_seg` and `ip_out` = `disp`.
- R7: `taken` is high for classes 0, 1 and 2 and for a loop that branches, and `flush` is high exactly when `taken` is high.
- R8: Class 3 (plain loop): `cx_out` = `cx_in` - 1; if that is nonzero the offset becomes the short target of R4, else `ip_in` + `ins_len` with `taken` low.
- R9: A loop class with `cx_in` = 0 gives `cx_out` = FFFFh, and the loop branch condition on the count counts as met.
- R10: Class 4 branches only when the decremented count is nonzero and `zf` = 1; class 5 only when it is nonzero and `zf` = 0; both decrement the count as in R8.
- R11: Classes 0, 1, 2, 6 and 7 leave `cx_out` = `cx_in`; classes 6 and 7 fall through to `ip_in` + `ins_len` with `cs_out` = `cs_in` and `taken` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Decoded transfer present this cycle |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Offset of the transfer instruction |
| ins_len | input | 4 | Length of the transfer instruction in bytes |
| op_class | input | 3 | Transfer class, encoding as in R4 to R11 |
| disp | input | 16 | Displacement (low byte for short forms) or far offset |
| far_seg | input | 16 | Segment field of a far jump |
| cx_in | input | 16 | Count register before the instruction |
| zf | input | 1 | Zero flag |
| out_valid | output | 1 | Result valid |
| cs_out | output | 16 | New code segment |
| ip_out | output | 16 | New offset |
| cx_out | output | 16 | Updated count register |
| phys_addr | output | 20 | Physical fetch address |
| taken | output | 1 | Flow was redirected |
| flush | output | 1 | Prefetch queue flush request |

## Verification
Random transfers of every class with random segments, offsets, lengths, displacements, counts and flag values compare all outputs against a bench model; negative displacements and offsets near FFFFh show whether sign extension and modulo-2^16 wrap are right, and large segments show the 20-bit wrap. Directed cases separate count values 0, 1 and 2 on each loop form with both flag values, which tells the wraparound rule apart from a plain nonzero test and the two conditional forms from each other. The worked short-jump example and the reserved classes pin down the length-relative base and the fall-through path, and an idle cycle after every transfer shows the hold behaviour.

// File: rtl/bls_pkg.sv
// Package: shared transfer-class encoding and widths for the branch/loop sequencer.
// Assumes a 3-bit class field driven by the decoder.
package bls_pkg;
    typedef enum logic [2:0] {
        XF_SHORT  = 3'd0,
        XF_NEAR   = 3'd1,
        XF_FAR    = 3'd2,
        XF_LOOP   = 3'd3,
        XF_LOOPZ  = 3'd4,
        XF_LOOPNZ = 3'd5,
        XF_RSV6   = 3'd6,
        XF_RSV7   = 3'd7
    } xfer_op_e;
endpackage

// File: rtl/bls_loop_eval.sv
// Loop evaluator: decrements the count for loop classes and decides whether
// the loop branches. Assumes the count wraps modulo 2^CNT_W.
module bls_loop_eval
    import bls_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  xfer_op_e           op,
    input  logic [CNT_W-1:0]   cnt_in,
    input  logic               zf,
    output logic [CNT_W-1:0]   cnt_out,
    output logic               loop_go
);
    logic [CNT_W-1:0] cnt_dec;
    logic             cnt_live;

    // Decrement and nonzero test shared by all loop forms.
    always_comb begin
        cnt_dec  = cnt_in - CNT_W'(1);
        cnt_live = (cnt_dec != '0);
    end

    // Select count result and branch decision per class.
    always_comb begin
        cnt_out = cnt_in;
        loop_go = 1'b0;
        case (op)
            XF_LOOP: begin
                cnt_out = cnt_dec;
                loop_go = cnt_live;
            end
            XF_LOOPZ: begin
                cnt_out = cnt_dec;
                loop_go = cnt_live & zf;
            end
            XF_LOOPNZ: begin
                cnt_out = cnt_dec;
                loop_go = cnt_live & ~zf;
            end
            default: begin
                cnt_out = cnt_in;
                loop_go = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/bls_target.sv
// Target generator: forms the next segment and offset for every class.
// Relative targets are based on the offset after the instruction; offsets
// wrap modulo 2^OFS_W. loop_go comes from the loop evaluator.
module bls_target
    import bls_pkg::*;
#(
    parameter int OFS_W   = 16,
    parameter int LEN_W   = 4,
    parameter int SHORT_W = 8
) (
    input  xfer_op_e           op,
    input  logic [OFS_W-1:0]   seg_in,
    input  logic [OFS_W-1:0]   ofs_in,
    input  logic [LEN_W-1:0]   len,
    input  logic [OFS_W-1:0]   disp,
    input  logic [OFS_W-1:0]   far_seg,
    input  logic               loop_go,
    output logic [OFS_W-1:0]   seg_out,
    output logic [OFS_W-1:0]   ofs_out,
    output logic               redirect
);
    localparam int EXT_W = OFS_W - SHORT_W;

    logic [OFS_W-1:0] ofs_seq;
    logic [OFS_W-1:0] short_tgt;
    logic [OFS_W-1:0] near_tgt;

    // Sequential offset and the two relative target candidates.
    always_comb begin
        ofs_seq   = ofs_in + OFS_W'(len);
        short_tgt = ofs_seq + {{EXT_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
        near_tgt  = ofs_seq + disp;
    end

    // Pick the result for the decoded class.
    always_comb begin
        seg_out  = seg_in;
        ofs_out  = ofs_seq;
        redirect = 1'b0;
        case (op)
            XF_SHORT: begin
                ofs_out  = short_tgt;
                redirect = 1'b1;
            end
            XF_NEAR: begin
                ofs_out  = near_tgt;
                redirect = 1'b1;
            end
            XF_FAR: begin
                seg_out  = far_seg;
                ofs_out  = disp;
                redirect = 1'b1;
            end
            XF_LOOP, XF_LOOPZ, XF_LOOPNZ: begin
                ofs_out  = loop_go ? short_tgt : ofs_seq;
                redirect = loop_go;
            end
            default: begin
                ofs_out  = ofs_seq;
                redirect = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/bls_phys_addr.sv
// Physical address former: segment shifted left by SEG_SHIFT plus the
// zero-extended offset, wrapping modulo 2^(OFS_W+SEG_SHIFT).
module bls_phys_addr #(
    parameter int OFS_W     = 16,
    parameter int SEG_SHIFT = 4,
    localparam int PA_W     = OFS_W + SEG_SHIFT
) (
    input  logic [OFS_W-1:0] seg,
    input  logic [OFS_W-1:0] ofs,
    output logic [PA_W-1:0]  pa
);
    // Aligned add of the shifted segment and the offset.
    always_comb begin
        pa = {seg, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, ofs};
    end
endmodule

// File: rtl/branch_loop_seq.sv
// Branch and loop sequencer top: computes next CS:IP, updated CX and the
// physical fetch address for a decoded transfer, registered one cycle after
// in_valid. Assumes the decoder supplies the instruction length and class.
module branch_loop_seq
    import bls_pkg::*;
#(
    parameter int OFS_W     = 16,
    parameter int LEN_W     = 4,
    parameter int SHORT_W   = 8,
    parameter int SEG_SHIFT = 4,
    localparam int PA_W     = OFS_W + SEG_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OFS_W-1:0]  cs_in,
    input  logic [OFS_W-1:0]  ip_in,
    input  logic [LEN_W-1:0]  ins_len,
    input  logic [2:0]        op_class,
    input  logic [OFS_W-1:0]  disp,
    input  logic [OFS_W-1:0]  far_seg,
    input  logic [OFS_W-1:0]  cx_in,
    input  logic              zf,
    output logic              out_valid,
    output logic [OFS_W-1:0]  cs_out,
    output logic [OFS_W-1:0]  ip_out,
    output logic [OFS_W-1:0]  cx_out,
    output logic [PA_W-1:0]   phys_addr,
    output logic              taken,
    output logic              flush
);
    xfer_op_e         op;
    logic [OFS_W-1:0] cx_nxt;
    logic             loop_go;
    logic [OFS_W-1:0] cs_nxt;
    logic [OFS_W-1:0] ip_nxt;
    logic             redirect;
    logic [PA_W-1:0]  pa_nxt;

    // Class field to enum.
    always_comb op = xfer_op_e'(op_class);

    bls_loop_eval #(.CNT_W(OFS_W)) u_loop (
        .op(op), .cnt_in(cx_in), .zf(zf),
        .cnt_out(cx_nxt), .loop_go(loop_go)
    );

    bls_target #(.OFS_W(OFS_W), .LEN_W(LEN_W), .SHORT_W(SHORT_W)) u_tgt (
        .op(op), .seg_in(cs_in), .ofs_in(ip_in), .len(ins_len),
        .disp(disp), .far_seg(far_seg), .loop_go(loop_go),
        .seg_out(cs_nxt), .ofs_out(ip_nxt), .redirect(redirect)
    );

    bls_phys_addr #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_pa (
        .seg(cs_nxt), .ofs(ip_nxt), .pa(pa_nxt)
    );

    // Result register: load on in_valid, hold data and drop pulses otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            cs_out    <= '0;
            ip_out    <= '0;
            cx_out    <= '0;
            phys_addr <= '0;
            taken     <= 1'b0;
            flush     <= 1'b0;
        end else if (in_valid) begin
            out_valid <= 1'b1;
            cs_out    <= cs_nxt;
            ip_out    <= ip_nxt;
            cx_out    <= cx_nxt;
            phys_addr <= pa_nxt;
            taken     <= redirect;
            flush     <= redirect;
        end else begin
            out_valid <= 1'b0;
            taken     <= 1'b0;
            flush     <= 1'b0;
        end
    end

    // R2: a strobe yields a valid result on the next cycle.
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R7: no flush or taken without a valid result.
    assert_flush_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flush || taken) |-> out_valid);

    // R7: unconditional jumps always redirect and flush.
    assert_jump_flushes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class <= 3'd2) |=> (taken && flush));

    // R6: far jump loads the segment field.
    assert_far_segment_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class == 3'd2) |=> (cs_out == $past(far_seg)));

    // R8: loop classes decrement the count by one.
    assert_loop_decrement_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class >= 3'd3 && op_class <= 3'd5)
            |=> (cx_out == $past(cx_in) - OFS_W'(1)));

    // R11: non-loop classes keep the count.
    assert_count_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_class <= 3'd2 || op_class >= 3'd6))
            |=> (cx_out == $past(cx_in)));

    // R2: idle cycle keeps the offset.
    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && $past(rst_n)) |=> $stable(ip_out));
endmodule

// File: tb/test_branch_loop_seq.sv
module test_branch_loop_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NRAND      = 600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] cs_in = '0, ip_in = '0, disp = '0, far_seg = '0, cx_in = '0;
    logic [3:0]  ins_len = '0;
    logic [2:0]  op_class = '0;
    logic        zf = 1'b0;
    logic        out_valid, taken, flush;
    logic [15:0] cs_out, ip_out, cx_out;
    logic [19:0] phys_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_loop_seq i_branch_loop_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cs_in(cs_in),
        .ip_in(ip_in), .ins_len(ins_len), .op_class(op_class), .disp(disp),
        .far_seg(far_seg), .cx_in(cx_in), .zf(zf), .out_valid(out_valid),
        .cs_out(cs_out), .ip_out(ip_out), .cx_out(cx_out),
        .phys_addr(phys_addr), .taken(taken), .flush(flush)
    );

    typedef struct packed {
        logic [15:0] cs;
        logic [15:0] ip;
        logic [15:0] cx;
        logic [19:0] pa;
        logic        tk;
    } exp_t;

    function automatic exp_t model(input logic [2:0] oc, input logic [15:0] cs,
                                   input logic [15:0] ip, input logic [3:0] len,
                                   input logic [15:0] d, input logic [15:0] fs,
                                   input logic [15:0] cx, input logic z);
        exp_t e;
        logic [15:0] seq, sht, dec;
        bit go;
        seq = ip + {12'd0, len};
        sht = seq + {{8{d[7]}}, d[7:0]};
        dec = cx - 16'd1;
        e.cs = cs; e.ip = seq; e.cx = cx; e.tk = 1'b0;
        case (oc)
            3'd0: begin e.ip = sht; e.tk = 1'b1; end
            3'd1: begin e.ip = seq + d; e.tk = 1'b1; end
            3'd2: begin e.cs = fs; e.ip = d; e.tk = 1'b1; end
            3'd3, 3'd4, 3'd5: begin
                e.cx = dec;
                go = (dec != 16'd0);
                if (oc == 3'd4) go = go && z;
                if (oc == 3'd5) go = go && !z;
                e.tk = go;
                if (go) e.ip = sht;
            end
            default: ;
        endcase
        e.pa = ({4'd0, e.cs} << 4) + {4'd0, e.ip};
        return e;
    endfunction

    function automatic string req_of(input logic [2:0] oc);
        case (oc)
            3'd0: return "R4";
            3'd1: return "R5";
            3'd2: return "R6";
            3'd3: return "R8";
            3'd4, 3'd5: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Apply one transfer, check result, then check the idle hold (R2).
    task automatic run_op(input logic [2:0] oc, input logic [15:0] cs,
                          input logic [15:0] ip, input logic [3:0] len,
                          input logic [15:0] d, input logic [15:0] fs,
                          input logic [15:0] cx, input logic z);
        exp_t e;
        string r;
        e = model(oc, cs, ip, len, d, fs, cx, z);
        r = req_of(oc);
        @(negedge clk);
        op_class = oc; cs_in = cs; ip_in = ip; ins_len = len;
        disp = d; far_seg = fs; cx_in = cx; zf = z; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2", "out_valid", {31'd0, out_valid}, 32'd1);
        chk(r, "cs_out", {16'd0, cs_out}, {16'd0, e.cs});
        chk(r, "ip_out", {16'd0, ip_out}, {16'd0, e.ip});
        chk((oc >= 3'd3 && oc <= 3'd5) ? (cx == 16'd0 ? "R9" : "R8") : "R11",
            "cx_out", {16'd0, cx_out}, {16'd0, e.cx});
        chk("R3", "phys_addr", {12'd0, phys_addr}, {12'd0, e.pa});
        chk("R7", "taken", {31'd0, taken}, {31'd0, e.tk});
        chk("R7", "flush", {31'd0, flush}, {31'd0, e.tk});
        @(negedge clk);
        chk("R2", "idle out_valid", {31'd0, out_valid}, 32'd0);
        chk("R2", "idle flush", {30'd0, taken, flush}, 32'd0);
        chk("R2", "idle hold ip", {16'd0, ip_out}, {16'd0, e.ip});
        chk("R2", "idle hold pa", {12'd0, phys_addr}, {12'd0, e.pa});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "out_valid", {31'd0, out_valid}, 32'd0);
        chk("R1", "cs/ip", {cs_out, ip_out}, 32'd0);
        chk("R1", "cx_out", {16'd0, cx_out}, 32'd0);
        chk("R1", "phys_addr", {12'd0, phys_addr}, 32'd0);
        chk("R1", "taken/flush", {30'd0, taken, flush}, 32'd0);
        rst_n = 1'b1;

        // R4/R3 worked example: 0723:0009, EB 04 -> 000F, 0723F
        run_op(3'd0, 16'h0723, 16'h0009, 4'd2, 16'h0004, 16'h0, 16'h0055, 1'b0);
        chk("R4", "example ip", {16'd0, ip_out}, 32'h000F);
        chk("R3", "example pa", {12'd0, phys_addr}, 32'h0723F);
        // R4 backward short and offset wrap
        run_op(3'd0, 16'h1000, 16'h0002, 4'd2, 16'h0080, 16'h0, 16'h0, 1'b0);
        run_op(3'd0, 16'h1000, 16'hFFFE, 4'd2, 16'h007F, 16'h0, 16'h0, 1'b0);
        // R5 near with negative displacement
        run_op(3'd1, 16'h2000, 16'h0100, 4'd3, 16'hFF00, 16'h0, 16'h7, 1'b1);
        // R6 far, R3 20-bit wrap
        run_op(3'd2, 16'h1234, 16'h5678, 4'd5, 16'hFFFF, 16'hFFFF, 16'h3, 1'b0);
        // R8/R9/R10: counts 0,1,2 on each loop form, both flag values
        for (int oc = 3; oc <= 5; oc++)
            for (int c = 0; c <= 2; c++)
                for (int z = 0; z <= 1; z++)
                    run_op(3'(oc), 16'h0400, 16'h0020, 4'd2, 16'h00F0, 16'h0,
                           16'(c), 1'(z));
        // R11 reserved classes
        run_op(3'd6, 16'h0050, 16'hFFFF, 4'd1, 16'h1234, 16'h9999, 16'hABCD, 1'b1);
        run_op(3'd7, 16'hF000, 16'h0010, 4'd4, 16'h00FF, 16'h1111, 16'h0000, 1'b0);

        // Random mix
        for (int i = 0; i < NRAND; i++)
            run_op(3'($urandom_range(0, 7)), 16'($urandom), 16'($urandom),
                   4'($urandom_range(1, 6)), 16'($urandom), 16'($urandom),
                   16'($urandom_range(0, 3) == 0 ? $urandom_range(0, 2) : $urandom),
                   1'($urandom));
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule